// File: doc/BRIEF.md
# Segment Translation and Limit Checker

This block turns a segmented logical address into a linear address. A caller gives a segment selector, an offset and a read/write flag. The block looks up a descriptor in a small on-chip table. Each descriptor holds a linear base, an inclusive length limit and two access-rights bits (present, writable). If the access is legal, the block returns the base plus the offset. Otherwise it raises a protection fault and gives no address. The table is loaded one entry at a time through a configuration write port.

A real-mode input bypasses the table. In that mode the address is the selector shifted left by four plus the low 16 bits of the offset, kept to 20 bits. Because of this, different selector/offset pairs can give the same address. When no further translation stage follows, the linear address can be used directly as the physical address.

Every lookup is registered. The result appears one clock after the request, as a one-cycle valid pulse or a one-cycle fault pulse.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `out_valid`, `out_fault` and `out_addr` are zero and every descriptor is non-present, so a protected-mode lookup of any entry faults until that entry is written.
- R2: A protected-mode lookup with `real_mode`=0 of a present entry, with a legal offset and legal rights, gives `out_valid`=1 one cycle later, with `out_addr` = base + offset.
- R3: The limit check is inclusive. An offset equal to the entry's limit is legal. An offset greater than the limit faults.
- R4: A write lookup (`lk_write`=1) to an entry whose writable bit is 0 faults. A read lookup of the same entry succeeds.
- R5: A lookup of an entry whose present bit is 0 faults for both reads and writes.
- R6: `out_valid` and `out_fault` are never high together. Each is high only in the cycle right after a cycle with `lk_req`=1. `out_addr` is zero whenever `out_fault` is high. With no request, both stay low.
- R7: With `real_mode`=1 the result is always valid, with `out_addr` = (`lk_sel`·16 + `lk_ofs[15:0]`) mod 2^20 and bits 31:20 zero. The table contents, the rights, `lk_write` and `lk_ofs[31:16]` have no effect. Pairs such as 1:0 and 0:16 give the same address.
- R8: A configuration write is used by lookups issued in later cycles. A lookup issued in the same cycle as a write to its entry sees the entry's previous contents.
- R9: The descriptor index is `lk_sel[2:0]`. Bits 15:3 of the selector are ignored in protected mode.
- R10: In protected mode, base + offset wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor index to write |
| cfg_base | input | 32 | Linear base for the written entry |
| cfg_limit | input | 20 | Inclusive offset limit for the written entry |
| cfg_present | input | 1 | Present bit for the written entry |
| cfg_writable | input | 1 | Writable bit for the written entry |
| lk_req | input | 1 | Lookup request |
| lk_sel | input | 16 | Segment selector |
| lk_ofs | input | 32 | Offset within the segment |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| real_mode | input | 1 | 1 = shift-and-add addressing without checks |
| out_valid | output | 1 | One-cycle pulse: translated address available |
| out_fault | output | 1 | One-cycle pulse: protection fault |
| out_addr | output | 32 | Linear address; zero on fault |

## Verification
Each lookup result is due exactly one clock after the edge that takes the request. The bench therefore drives a request on a falling edge and samples `out_valid`, `out_fault` and `out_addr` on the next falling edge, after exactly one rising edge. It then deasserts the request and samples again one cycle later to confirm that both pulses have dropped. Descriptor writes take effect at the rising edge that stores them. The same-cycle case drives a write and a lookup of the same entry on one falling edge and expects the old contents in the result one cycle later. A lookup on the following cycle must then see the new contents.

// File: rtl/seg_pkg.sv
package seg_pkg;

  // Access rights stored with each descriptor
  typedef struct packed {
    logic present;
    logic writable;
  } seg_rights_t;

  // Source of the registered result
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_OK    = 2'd1,
    RES_FAULT = 2'd2
  } seg_res_e;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int BASE_W = 32,
  parameter int LIM_W  = 20,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_lim,
  input  seg_rights_t       wr_rights,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_lim,
  output seg_rights_t       rd_rights
);

  logic [BASE_W-1:0] base_q   [N_DESC];
  logic [LIM_W-1:0]  lim_q    [N_DESC];
  seg_rights_t       rights_q [N_DESC];

  // One register set per entry, each with its own clock enable
  for (genvar g = 0; g < N_DESC; g++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]   <= '0;
        lim_q[g]    <= '0;
        rights_q[g] <= '0;
      end else if (ent_en) begin
        base_q[g]   <= wr_base;
        lim_q[g]    <= wr_lim;
        rights_q[g] <= wr_rights;
      end
    end
  end

  // Read port: plain mux, old contents visible in the write cycle
  always_comb begin
    rd_base   = base_q[rd_idx];
    rd_lim    = lim_q[rd_idx];
    rd_rights = rights_q[rd_idx];
  end

endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
  import seg_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 20,
  parameter int OFS_W  = 32
) (
  input  logic [BASE_W-1:0] base,
  input  logic [LIM_W-1:0]  lim,
  input  seg_rights_t       rights,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              is_write,
  output logic              fault,
  output logic [BASE_W-1:0] lin_addr
);

  logic over_limit;
  logic rights_bad;

  always_comb begin
    // Inclusive limit: offset == limit is still inside the segment
    over_limit = (ofs > OFS_W'(lim));
    rights_bad = !rights.present || (is_write && !rights.writable);
    fault      = over_limit || rights_bad;
    lin_addr   = base + BASE_W'(ofs);
  end

endmodule

// File: rtl/seg_real_addr.sv
module seg_real_addr #(
  parameter int SEL_W   = 16,
  parameter int OFS_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int SHIFT   = 4,
  parameter int REAL_W  = 20,
  parameter int OFS_LOW = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] lin_addr
);

  logic [REAL_W-1:0] seg_part;
  logic [REAL_W-1:0] ofs_part;
  logic [REAL_W-1:0] sum;

  always_comb begin
    seg_part = REAL_W'({sel, {SHIFT{1'b0}}});
    ofs_part = REAL_W'(ofs[OFS_LOW-1:0]);
    sum      = seg_part + ofs_part;    // wraps on REAL_W bits
    lin_addr = ADDR_W'(sum);
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int SEL_W  = 16,
  parameter int OFS_W  = 32,
  parameter int BASE_W = 32,
  parameter int LIM_W  = 20,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              cfg_present,
  input  logic              cfg_writable,
  input  logic              lk_req,
  input  logic [SEL_W-1:0]  lk_sel,
  input  logic [OFS_W-1:0]  lk_ofs,
  input  logic              lk_write,
  input  logic              real_mode,
  output logic              out_valid,
  output logic              out_fault,
  output logic [BASE_W-1:0] out_addr
);

  seg_rights_t       wr_rights;
  logic [BASE_W-1:0] d_base;
  logic [LIM_W-1:0]  d_lim;
  seg_rights_t       d_rights;
  logic              p_fault;
  logic [BASE_W-1:0] p_addr;
  logic [BASE_W-1:0] r_addr;

  seg_res_e          res_d, res_q;
  logic [BASE_W-1:0] addr_d, addr_q;

  assign wr_rights = '{present: cfg_present, writable: cfg_writable};

  seg_desc_table #(
    .N_DESC (N_DESC),
    .BASE_W (BASE_W),
    .LIM_W  (LIM_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_base   (cfg_base),
    .wr_lim    (cfg_limit),
    .wr_rights (wr_rights),
    .rd_idx    (lk_sel[IDX_W-1:0]),
    .rd_base   (d_base),
    .rd_lim    (d_lim),
    .rd_rights (d_rights)
  );

  seg_prot_check #(
    .BASE_W (BASE_W),
    .LIM_W  (LIM_W),
    .OFS_W  (OFS_W)
  ) u_prot (
    .base     (d_base),
    .lim      (d_lim),
    .rights   (d_rights),
    .ofs      (lk_ofs),
    .is_write (lk_write),
    .fault    (p_fault),
    .lin_addr (p_addr)
  );

  seg_real_addr #(
    .SEL_W  (SEL_W),
    .OFS_W  (OFS_W),
    .ADDR_W (BASE_W)
  ) u_real (
    .sel      (lk_sel),
    .ofs      (lk_ofs),
    .lin_addr (r_addr)
  );

  // Next-state selection
  always_comb begin
    res_d  = RES_NONE;
    addr_d = '0;
    if (lk_req) begin
      if (real_mode) begin
        res_d  = RES_OK;
        addr_d = r_addr;
      end else if (p_fault) begin
        res_d  = RES_FAULT;
      end else begin
        res_d  = RES_OK;
        addr_d = p_addr;
      end
    end
  end

  // Result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= RES_NONE;
      addr_q <= '0;
    end else begin
      res_q  <= res_d;
      addr_q <= addr_d;
    end
  end

  assign out_valid = (res_q == RES_OK);
  assign out_fault = (res_q == RES_FAULT);
  assign out_addr  = addr_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              real_mode,
  input logic              out_valid,
  input logic              out_fault,
  input logic [ADDR_W-1:0] out_addr
);

  AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_fault)); // R6

  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_fault) |-> $past(lk_req)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lk_req)) |-> (!out_valid && !out_fault)); // R6

  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_addr == '0)); // R6

  AST_REAL_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && lk_req && real_mode) |-> out_valid); // R7

  AST_REAL_20BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(real_mode)) |-> (out_addr[ADDR_W-1:20] == '0)); // R7

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(BASE_W)) u_seg_xlate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .real_mode (real_mode),
  .out_valid (out_valid),
  .out_fault (out_fault),
  .out_addr  (out_addr)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [19:0] cfg_limit;
  logic        cfg_present, cfg_writable;
  logic        lk_req;
  logic [15:0] lk_sel;
  logic [31:0] lk_ofs;
  logic        lk_write, real_mode;
  logic        out_valid, out_fault;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_present(cfg_present), .cfg_writable(cfg_writable),
    .lk_req(lk_req), .lk_sel(lk_sel), .lk_ofs(lk_ofs), .lk_write(lk_write),
    .real_mode(real_mode),
    .out_valid(out_valid), .out_fault(out_fault), .out_addr(out_addr)
  );

  typedef struct packed {
    logic        rm;
    logic [15:0] sel;
    logic [31:0] ofs;
    logic        wr;
    logic        flt;
    logic [31:0] addr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0000, 32'h0000_0010, 1'b0, 1'b0, 32'h0001_0010, 8'd2},  // R2
    '{1'b0, 16'h0000, 32'h0000_0FFF, 1'b1, 1'b0, 32'h0001_0FFF, 8'd3},  // R3 equal
    '{1'b0, 16'h0000, 32'h0000_1000, 1'b0, 1'b1, 32'h0000_0000, 8'd3},  // R3 over
    '{1'b0, 16'h0001, 32'h0000_0000, 1'b0, 1'b0, 32'h2000_0000, 8'd4},  // R4 read
    '{1'b0, 16'h0001, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000, 8'd4},  // R4 write
    '{1'b0, 16'h0003, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 8'd5},  // R5 read
    '{1'b0, 16'h0003, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000, 8'd5},  // R5 write
    '{1'b0, 16'h0002, 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0000, 8'd10}, // R10
    '{1'b0, 16'h0002, 32'h0000_01FF, 1'b1, 1'b0, 32'h0000_00FF, 8'd10}, // R10
    '{1'b0, 16'hFFF8, 32'h0000_0020, 1'b0, 1'b0, 32'h0001_0020, 8'd9},  // R9
    '{1'b0, 16'h000B, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 8'd9},  // R9
    '{1'b1, 16'h0001, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0010, 8'd7},  // R7 alias a
    '{1'b1, 16'h0000, 32'h0000_0010, 1'b0, 1'b0, 32'h0000_0010, 8'd7},  // R7 alias b
    '{1'b1, 16'hFFFF, 32'h0000_FFFF, 1'b0, 1'b0, 32'h0000_FFEF, 8'd7},  // R7 wrap
    '{1'b1, 16'h1233, 32'hABCD_0015, 1'b1, 1'b0, 32'h0001_2345, 8'd7},  // R7 ignores
    '{1'b0, 16'h0005, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 8'd1}   // R1 untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] i, input logic [31:0] b,
                           input logic [19:0] l, input logic p, input logic w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_base = b; cfg_limit = l;
    cfg_present = p; cfg_writable = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive at a falling edge, result due after one rising edge, then idle cycle
  task automatic lookup(input logic rm, input logic [15:0] s, input logic [31:0] o,
                        input logic w, input logic ef, input logic [31:0] ea,
                        input string req);
    lk_req = 1'b1; real_mode = rm; lk_sel = s; lk_ofs = o; lk_write = w;
    @(negedge clk);
    lk_req = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, {31'd0, !ef});
    chk({req, " fault"}, {31'd0, out_fault}, {31'd0, ef});
    chk({req, " addr"},  out_addr, ea);
    @(negedge clk);
    chk("R6 pulse drop", {30'd0, out_valid, out_fault}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_limit = '0;
    cfg_present = 1'b0; cfg_writable = 1'b0; lk_req = 1'b0; lk_sel = '0;
    lk_ofs = '0; lk_write = 1'b0; real_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 fault", {31'd0, out_fault}, 32'd0);
    chk("R1 addr",  out_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: entry 0 is non-present before any write
    lookup(1'b0, 16'h0000, 32'h0, 1'b0, 1'b1, 32'h0, "R1 empty");

    cfg_write(3'd0, 32'h0001_0000, 20'h00FFF, 1'b1, 1'b1);
    cfg_write(3'd1, 32'h2000_0000, 20'h00000, 1'b1, 1'b0);
    cfg_write(3'd2, 32'hFFFF_FF00, 20'hFFFFF, 1'b1, 1'b1);
    cfg_write(3'd3, 32'h0000_1234, 20'hFFFFF, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i].rm, VEC[i].sel, VEC[i].ofs, VEC[i].wr, VEC[i].flt,
             VEC[i].addr, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R8: same-cycle write and lookup of entry 6 sees old (non-present) contents
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_base = 32'h0000_0500; cfg_limit = 20'h000FF;
    cfg_present = 1'b1; cfg_writable = 1'b1;
    lookup(1'b0, 16'h0006, 32'h0000_0010, 1'b0, 1'b1, 32'h0, "R8 same cycle");
    cfg_we = 1'b0;
    // R8: next lookup sees the new contents
    lookup(1'b0, 16'h0006, 32'h0000_0010, 1'b1, 1'b0, 32'h0000_0510, "R8 later");
    // R3: new entry limit boundary
    lookup(1'b0, 16'h0006, 32'h0000_00FF, 1'b0, 1'b0, 32'h0000_05FF, "R3 lim6");
    lookup(1'b0, 16'h0006, 32'h0000_0100, 1'b0, 1'b1, 32'h0, "R3 over6");
    // R2: back-to-back requests give one result per cycle
    lk_req = 1'b1; real_mode = 1'b0; lk_sel = 16'h0000; lk_ofs = 32'h4; lk_write = 1'b0;
    @(negedge clk);
    lk_ofs = 32'h8;
    chk("R2 b2b first", out_addr, 32'h0001_0004);
    @(negedge clk);
    lk_req = 1'b0;
    chk("R2 b2b second", out_addr, 32'h0001_0008);
    chk("R2 b2b valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R6 idle", {30'd0, out_valid, out_fault}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule